// File: doc/BRIEF.md
# External Bus Chip-Select Cycle Sequencer

This block turns single read or write requests from an on-chip master into timed cycles on an external parallel bus that is split into eight chip-select areas. The top three address bits pick the area, and the block drives that area's active-low select line. For the whole cycle it holds the address stable and gives a read or write strobe of two clocks.

A 16-bit control register gives each area two options. The first adds one lead cycle before the strobes, in which the select and the address are already driven. The second adds one trailing cycle after the strobes, in which the select and the address are still held. Each area also has a burst-ROM mode input. When it is set, the trailing cycle is dropped for reads but kept for writes. The block takes the area options at the moment it accepts a request, so changing the register during a cycle changes only later cycles.

The state sequence is IDLE → (SETUP) → T1 → T2 → (HOLD) → FIN → IDLE. IDLE→SETUP is taken on an accepted request when the lead cycle is enabled, and IDLE→T1 when it is not. T1→T2 is always taken. T2→HOLD is taken when the trailing cycle applies, and T2→FIN when it does not. SETUP→T1, HOLD→FIN and FIN→IDLE are unconditional.

Top module: `csx_bus_seq`

## Requirements
- R1: The area is address bits [23:21]. Only that area's line in `ext_cs_n` (bit n for area n) is driven low, and all lines are high outside an access.
- R2: `cfg_rdata` reads the control register. It resets to 0 and every bit can be written through `cfg_we`/`cfg_wdata`.
- R3: When control bit 8+n is 1, an access to area n begins with one extra cycle. In that cycle the select and address are driven and no strobe is asserted.
- R4: When control bit n is 1, an access to area n ends with one extra cycle. In that cycle the select and address are held and no strobe is asserted.
- R5: When `brom_mode[n]` is 1, a read of area n gets no trailing cycle, whatever control bit n holds. A write still follows control bit n.
- R6: `ext_rd_n` (reads) or `ext_wr_n` (writes) is low for exactly two cycles, T1 and T2. The other strobe stays high, and the two are never low together.
- R7: The address and the select lines do not change from the first cycle of a sequence to its last.
- R8: On a read, `rsp_rdata` holds the value that `ext_data_in` had at the clock edge ending T2. On a write, `ext_data_oe` is high and `ext_data_out` equals the request data from T1 through any trailing cycle.
- R9: `done` is high for exactly one clock, the cycle right after the last select cycle. A `req` that arrives while the block is not idle is ignored.
- R10: A control register write made during an access has no effect on that access. It applies from the next accepted request onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 16 | Control register write value |
| cfg_rdata | output | 16 | Control register contents |
| brom_mode | input | 8 | Per-area burst-ROM mode flags |
| req | input | 1 | Access request, taken only when idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Access address |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read data captured at the end of T2 |
| done | output | 1 | One-cycle completion pulse |
| ext_addr | output | 24 | External address |
| ext_cs_n | output | 8 | Active-low area selects |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_data_out | output | 16 | Write data to the bus |
| ext_data_oe | output | 1 | Data bus output enable |
| ext_data_in | input | 16 | Read data from the bus |

## Verification
The bench checks each of the four combinations of lead and trailing cycle against where the strobe sits within the select window. A design with off-by-one state transitions would move the strobe or stretch it. It targets burst-ROM reads separately from burst-ROM writes: a design that dropped the trailing cycle for both, or for neither, fails one of the two. It presents valid read data only around the edge that ends T2, so a design that captures at T1 or at the trailing cycle returns a wrong value. It also rewrites the control register during an access and issues a request while busy, which exposes a design that reads the register live or restarts mid-cycle.

// File: rtl/csx_pkg.sv
package csx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_T1    = 3'd2,
        ST_T2    = 3'd3,
        ST_HOLD  = 3'd4,
        ST_FIN   = 3'd5
    } seq_state_t;
endpackage

// File: rtl/csx_ctrl_reg.sv
module csx_ctrl_reg #(
    parameter int NAREA = 8,
    localparam int CFG_W = 2 * NAREA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_val,
    output logic [CFG_W-1:0] cfg_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= wr_val;
        end
    end
endmodule

// File: rtl/csx_area_opts.sv
module csx_area_opts #(
    parameter int NAREA  = 8,
    localparam int AREA_W = $clog2(NAREA),
    localparam int CFG_W  = 2 * NAREA
) (
    input  logic [AREA_W-1:0] area,
    input  logic              is_write,
    input  logic [CFG_W-1:0]  cfg,
    input  logic [NAREA-1:0]  brom,
    output logic              lead_en,
    output logic              trail_en
);
    logic lead_bit;
    logic trail_bit;
    logic brom_bit;

    always_comb begin
        lead_bit  = cfg[NAREA + int'(area)];
        trail_bit = cfg[int'(area)];
        brom_bit  = brom[area];
        lead_en   = lead_bit;
        // burst-ROM reads drop the trailing cycle; writes keep it
        trail_en  = trail_bit & ~(brom_bit & ~is_write);
    end
endmodule

// File: rtl/csx_seq_fsm.sv
module csx_seq_fsm
    import csx_pkg::*;
#(
    parameter int NAREA = 8,
    parameter int AW    = 24,
    parameter int DW    = 16,
    localparam int AREA_W = $clog2(NAREA)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic              lead_en,
    input  logic              trail_en,
    input  logic [DW-1:0]     bus_din,
    output logic [DW-1:0]     rdata,
    output logic              done,
    output logic [AW-1:0]     bus_addr,
    output logic [NAREA-1:0]  bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [DW-1:0]     bus_dout,
    output logic              bus_oe
);
    seq_state_t state_q, state_d;

    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          we_q;
    logic          lead_q;
    logic          trail_q;
    logic [DW-1:0] rdata_q;
    logic          accept;
    logic [NAREA-1:0] area_hot;

    assign accept = (state_q == ST_IDLE) && req;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req) state_d = lead_en ? ST_SETUP : ST_T1;
            ST_SETUP: state_d = ST_T1;
            ST_T1:    state_d = ST_T2;
            ST_T2:    state_d = trail_q ? ST_HOLD : ST_FIN;
            ST_HOLD:  state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // request capture and read sampling
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            lead_q  <= 1'b0;
            trail_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                we_q    <= req_we;
                lead_q  <= lead_en;
                trail_q <= trail_en;
            end
            if (state_q == ST_T2 && !we_q) begin
                rdata_q <= bus_din;
            end
        end
    end

    for (genvar g = 0; g < NAREA; g++) begin : g_cs
        assign area_hot[g] = (addr_q[AW-1 -: AREA_W] == AREA_W'(g));
    end

    // outputs
    always_comb begin
        bus_addr = '0;
        bus_cs_n = '1;
        bus_rd_n = 1'b1;
        bus_wr_n = 1'b1;
        bus_dout = '0;
        bus_oe   = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SETUP: begin
                bus_addr = addr_q;
                bus_cs_n = ~area_hot;
            end
            ST_T1, ST_T2: begin
                bus_addr = addr_q;
                bus_cs_n = ~area_hot;
                bus_rd_n = we_q;
                bus_wr_n = ~we_q;
                bus_oe   = we_q;
                bus_dout = we_q ? wdata_q : '0;
            end
            ST_HOLD: begin
                bus_addr = addr_q;
                bus_cs_n = ~area_hot;
                bus_oe   = we_q;
                bus_dout = we_q ? wdata_q : '0;
            end
            ST_FIN: done = 1'b1;
            default: ;
        endcase
    end

    assign rdata = rdata_q;

    logic unused_lead;
    assign unused_lead = lead_q;
endmodule

// File: rtl/csx_bus_seq.sv
module csx_bus_seq #(
    parameter int NAREA = 8,
    parameter int AW    = 24,
    parameter int DW    = 16,
    localparam int AREA_W = $clog2(NAREA),
    localparam int CFG_W  = 2 * NAREA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic [NAREA-1:0] brom_mode,
    input  logic             req,
    input  logic             req_we,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic [DW-1:0]    rsp_rdata,
    output logic             done,
    output logic [AW-1:0]    ext_addr,
    output logic [NAREA-1:0] ext_cs_n,
    output logic             ext_rd_n,
    output logic             ext_wr_n,
    output logic [DW-1:0]    ext_data_out,
    output logic             ext_data_oe,
    input  logic [DW-1:0]    ext_data_in
);
    logic [CFG_W-1:0] cfg_q;
    logic             lead_en;
    logic             trail_en;

    csx_ctrl_reg #(.NAREA(NAREA)) ctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_val (cfg_wdata),
        .cfg_q  (cfg_q)
    );

    csx_area_opts #(.NAREA(NAREA)) opts_i (
        .area     (req_addr[AW-1 -: AREA_W]),
        .is_write (req_we),
        .cfg      (cfg_q),
        .brom     (brom_mode),
        .lead_en  (lead_en),
        .trail_en (trail_en)
    );

    csx_seq_fsm #(.NAREA(NAREA), .AW(AW), .DW(DW)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .lead_en   (lead_en),
        .trail_en  (trail_en),
        .bus_din   (ext_data_in),
        .rdata     (rsp_rdata),
        .done      (done),
        .bus_addr  (ext_addr),
        .bus_cs_n  (ext_cs_n),
        .bus_rd_n  (ext_rd_n),
        .bus_wr_n  (ext_wr_n),
        .bus_dout  (ext_data_out),
        .bus_oe    (ext_data_oe)
    );

    assign cfg_rdata = cfg_q;
endmodule

// File: rtl/csx_bus_seq_chk.sv
module csx_bus_seq_chk #(
    parameter int NAREA = 8,
    parameter int AW    = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    ext_addr,
    input logic [NAREA-1:0] ext_cs_n,
    input logic             ext_rd_n,
    input logic             ext_wr_n,
    input logic             ext_data_oe,
    input logic             done
);
    logic sel;
    assign sel = (ext_cs_n != '1);

    assert_one_area_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_cs_n));

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n));

    assert_strobe_in_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rd_n || !ext_wr_n) |-> sel);

    assert_stable_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && $past(sel)) |-> ($stable(ext_addr) && $stable(ext_cs_n)));

    assert_drive_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_data_oe |-> (sel && ext_rd_n));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(sel));
endmodule

bind csx_bus_seq csx_bus_seq_chk #(.NAREA(NAREA), .AW(AW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_addr    (ext_addr),
    .ext_cs_n    (ext_cs_n),
    .ext_rd_n    (ext_rd_n),
    .ext_wr_n    (ext_wr_n),
    .ext_data_oe (ext_data_oe),
    .done        (done)
);

// File: tb/csx_bus_seq_tb_top.sv
module csx_bus_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [7:0]  brom_mode = '0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] rsp_rdata;
    logic        done;
    logic [23:0] ext_addr;
    logic [7:0]  ext_cs_n;
    logic        ext_rd_n;
    logic        ext_wr_n;
    logic [15:0] ext_data_out;
    logic        ext_data_oe;
    logic [15:0] ext_data_in = 16'hDEAD;

    int n_total = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    csx_bus_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .brom_mode(brom_mode), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .done(done), .ext_addr(ext_addr), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n),
        .ext_wr_n(ext_wr_n), .ext_data_out(ext_data_out), .ext_data_oe(ext_data_oe),
        .ext_data_in(ext_data_in)
    );

    typedef struct packed {
        logic [2:0]  area;
        logic        we;
        logic [15:0] cfg;
        logic [7:0]  brom;
        logic        exp_lead;
        logic        exp_trail;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 1'b0, 16'h0000, 8'h00, 1'b0, 1'b0},
        '{3'd3, 1'b0, 16'h0800, 8'h00, 1'b1, 1'b0},
        '{3'd5, 1'b1, 16'h0020, 8'h00, 1'b0, 1'b1},
        '{3'd7, 1'b0, 16'h8080, 8'h00, 1'b1, 1'b1},
        '{3'd2, 1'b0, 16'h0404, 8'h04, 1'b1, 1'b0},
        '{3'd2, 1'b1, 16'h0404, 8'h04, 1'b1, 1'b1},
        '{3'd6, 1'b0, 16'hBF40, 8'hBF, 1'b0, 1'b1},
        '{3'd1, 1'b1, 16'hFD02, 8'h02, 1'b0, 1'b1}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    task automatic set_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // issue one access and check its shape; mid_cfg >= 0 writes the register during it
    task automatic run_access(input logic [2:0] area, input logic we, input bit exp_lead,
                              input bit exp_trail, input logic [15:0] val, input int mid_cfg);
        int n_sel = 0, n_strobe = 0, first_s = -1, last_s = -1, done_at = -1, n_oe = 0;
        int bad_cs = 0, bad_addr = 0, bad_wd = 0, bad_other = 0;
        int exp_len = 2 + int'(exp_lead) + int'(exp_trail);
        logic [23:0] a = {area, 21'h0A5C3};
        @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = val;
        ext_data_in = 16'hDEAD;
        @(negedge clk);
        req = 1'b0;
        for (int c = 0; c < 10; c++) begin
            bit strobe;
            if (c == 0 && mid_cfg >= 0) begin
                cfg_we = 1'b1;
                cfg_wdata = mid_cfg[15:0];
            end else begin
                cfg_we = 1'b0;
            end
            strobe = we ? !ext_wr_n : !ext_rd_n;
            if ((we ? !ext_rd_n : !ext_wr_n)) bad_other++;
            ext_data_in = 16'hDEAD;
            if (ext_cs_n != 8'hFF) begin
                if (ext_cs_n != ~(8'b1 << area)) bad_cs++;
                if (ext_addr != a) bad_addr++;
                if (strobe) begin
                    if (first_s < 0) first_s = n_sel;
                    last_s = n_sel;
                    n_strobe++;
                    if (!we && n_strobe == 2) ext_data_in = val;
                end
                if (ext_data_oe) begin
                    n_oe++;
                    if (ext_data_out != val) bad_wd++;
                end
                n_sel++;
            end
            if (done) begin
                if (done_at < 0) begin
                    done_at = c;
                    if (!we) chk(rsp_rdata == val, "R8 read data at T2 end", rsp_rdata, val);
                end else begin
                    bad_other++;
                end
            end
            @(negedge clk);
        end
        cfg_we = 1'b0;
        chk(bad_cs == 0, "R1 select line of area", bad_cs, 0);
        chk(n_sel == exp_len, "R3/R4 select window length", n_sel, exp_len);
        chk(first_s == int'(exp_lead), "R3 lead cycle before strobe", first_s, int'(exp_lead));
        chk(exp_len - 1 - last_s == int'(exp_trail), "R4 trail cycle after strobe",
            exp_len - 1 - last_s, int'(exp_trail));
        chk(n_strobe == 2 && bad_other == 0, "R6 strobe two cycles only", n_strobe, 2);
        chk(bad_addr == 0, "R7 address held", bad_addr, 0);
        chk(done_at == exp_len, "R9 done right after window", done_at, exp_len);
        if (we) chk(n_oe == 2 + int'(exp_trail) && bad_wd == 0, "R8 write data window",
                    n_oe, 2 + int'(exp_trail));
    endtask

    initial begin
        #(200000 * 5);
        n_total++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        chk(cfg_rdata == 16'h0000, "R2 reset value", cfg_rdata, 0);
        chk(ext_cs_n == 8'hFF && ext_rd_n && ext_wr_n && !done && !ext_data_oe,
            "R1 idle bus at reset", ext_cs_n, 8'hFF);
        rst_n = 1'b1;
        set_cfg(16'hA55A);
        chk(cfg_rdata == 16'hA55A, "R2 readback", cfg_rdata, 16'hA55A);
        set_cfg(16'h5AA5);
        chk(cfg_rdata == 16'h5AA5, "R2 readback inverse", cfg_rdata, 16'h5AA5);

        // vector table: R3 R4 R5 combinations
        for (int i = 0; i < NVEC; i++) begin
            set_cfg(VECS[i].cfg);
            brom_mode = VECS[i].brom;
            run_access(VECS[i].area, VECS[i].we, VECS[i].exp_lead, VECS[i].exp_trail,
                       16'h1000 + 16'(i) * 16'h0111, -1);
        end

        // R5: burst-ROM read of area 4 with trail bit set -> no trail cycle
        set_cfg(16'h0010);
        brom_mode = 8'h10;
        run_access(3'd4, 1'b0, 1'b0, 1'b0, 16'h4C4C, -1);
        brom_mode = 8'h00;

        // R10: register rewritten during access; this access uses old options
        set_cfg(16'h0000);
        run_access(3'd4, 1'b0, 1'b0, 1'b0, 16'h7E57, 16'h1010);
        chk(cfg_rdata == 16'h1010, "R10 mid-access write landed", cfg_rdata, 16'h1010);
        run_access(3'd4, 1'b1, 1'b1, 1'b1, 16'h8181, -1);

        // R9: request while busy is ignored
        set_cfg(16'h0000);
        @(negedge clk);
        req = 1'b1; req_we = 1'b0; req_addr = 24'h200000;
        @(negedge clk);
        req_addr = 24'hE00000;
        @(negedge clk);
        req = 1'b0;
        begin
            int extra = 0;
            for (int c = 0; c < 8; c++) begin
                if (ext_cs_n == 8'h7F) extra++;
                @(negedge clk);
            end
            chk(extra == 0, "R9 busy request ignored", extra, 0);
        end
        finish_run();
    end
endmodule